// File: doc/BRIEF.md
# BCH8 Error-Location Applier

This block sits behind an 8-bit-correcting BCH checker on a flash read path. One sector is 512 data bytes and is protected by a 14-byte code. The last code byte is reserved, so the codeword covers 525 bytes. When a sector has been read, the block first looks at the computed and the stored code words to decide whether any correction is needed. If correction is needed, it takes up to eight bit locations from the locator and applies each of them to the sector data buffer or to the spare-code buffer.

Each location counts bits back from the end of the codeword. The block turns each location into a byte offset and a bit index. A location in the data region flips one bit in the data buffer by reading the byte and then writing it back. A location in the code region overwrites one spare byte with a one-hot mask. A location past the start of the codeword is rejected and marks the whole sector as failed. The block also outputs the computed code with its first 13 bytes in reverse order, which is the form the locator expects. When all locations are handled, a one-cycle done pulse is raised together with the count of corrected locations or a failure flag.

Top module: `bch8_loc_apply`

## Requirements
- R1: `loc_code` byte i (bits 8i+7..8i) equals `calc_code` byte 12−i for i = 0..12, and byte 13 of `loc_code` is always 0x00. The output is combinational.
- R2: If `uncorr` is high when an idle `start` is sampled, `done` pulses on the next cycle with `fail`=1 and `fixed_cnt`=0, and neither buffer is written.
- R3: Otherwise, if all 14 bytes of `calc_code` are 0x00, `done` pulses on the next cycle with `fail`=0 and `fixed_cnt`=0, and no location is applied.
- R4: Otherwise, if all 14 bytes of `stored_code` are 0xFF (erased sector), the result is the same as in R3.
- R5: A location L (slot i at bits 13i+12..13i of `locs`) maps to byte position p = 524 − L/8 and bit index L mod 8. If p < 512, data byte p is read and then written back with bit (L mod 8) inverted.
- R6: If 512 ≤ p ≤ 524, spare byte p−512 is written with the value 1 << (L mod 8), and the old content of that byte is discarded.
- R7: A location with L/8 > 524 writes nothing. At completion, `fail`=1 and `fixed_cnt`=0. The other valid locations of the same run are still applied.
- R8: At most 8 locations are handled. An `err_cnt` above 8 is treated as 8.
- R9: n locations are handled in slot order, one every two cycles (read cycle, then write cycle). `done` is a one-cycle pulse, 2n cycles after the start edge. When no location is invalid, `fixed_cnt` = n, and it holds until the next start.
- R10: With `err_cnt`=0 and no screening condition, `done` pulses on the next cycle with `fixed_cnt`=0 and `fail`=0.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one sector; sampled only while idle |
| uncorr | input | 1 | Locator reports too many errors to correct |
| err_cnt | input | 4 | Number of valid location slots |
| locs | input | 104 | Eight 13-bit locations, slot i at bits 13i+12..13i |
| calc_code | input | 112 | Code computed from read data, byte i at bits 8i+7..8i |
| stored_code | input | 112 | Code read from the spare area |
| loc_code | output | 112 | Computed code reordered for the locator |
| dat_rd_en | output | 1 | Data buffer read strobe |
| dat_wr_en | output | 1 | Data buffer write strobe |
| dat_addr | output | 9 | Data buffer byte address |
| dat_wdata | output | 8 | Data buffer write byte |
| dat_rdata | input | 8 | Data buffer read byte, valid one cycle after the read strobe |
| spr_wr_en | output | 1 | Spare buffer write strobe |
| spr_addr | output | 4 | Spare buffer byte address |
| spr_wdata | output | 8 | Spare buffer write byte |
| busy | output | 1 | Locations are being applied |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sector failed (uncorrectable or invalid location) |
| fixed_cnt | output | 4 | Number of locations applied |

## Verification
`loc_code` is combinational, so it is checked in the same cycle its input changes. A screened or empty start must produce `done` at the first falling edge after the start edge. A run of n locations must produce `done` exactly 2n edges after the start edge. The bench counts edges from the start edge, checks that `done` appears on exactly that count, and only then compares `fixed_cnt`, `fail` and both buffers against a behavioural model that applies the same locations in slot order.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} fsm_t;
    typedef enum logic [1:0] {TGT_DATA, TGT_SPARE, TGT_BAD} tgt_t;
endpackage

// File: rtl/bchfix_reverse.sv
module bchfix_reverse #(
    parameter int NBYTES = 13
) (
    input  logic [NBYTES*8-1:0] code_in,
    output logic [NBYTES*8-1:0] code_out
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_rev
        assign code_out[g*8 +: 8] = code_in[(NBYTES-1-g)*8 +: 8];
    end
endmodule

// File: rtl/bchfix_screen.sv
module bchfix_screen #(
    parameter int CODE_BYTES = 14
) (
    input  logic [CODE_BYTES*8-1:0] calc_code,
    input  logic [CODE_BYTES*8-1:0] stored_code,
    output logic                    calc_zero,
    output logic                    erased,
    output logic [CODE_BYTES*8-1:0] loc_code
);
    localparam int REV_N = CODE_BYTES - 1;

    logic [REV_N*8-1:0] rev;

    assign calc_zero = ~|calc_code;
    assign erased    = &stored_code;

    bchfix_reverse #(.NBYTES(REV_N)) u_rev (
        .code_in  (calc_code[REV_N*8-1:0]),
        .code_out (rev)
    );

    // reserved last byte handed on as zero
    assign loc_code = {8'h00, rev};
endmodule

// File: rtl/bchfix_locmap.sv
module bchfix_locmap
    import bchfix_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int CODE_BYTES = 14,
    parameter int LOC_W      = 13,
    localparam int SPAN      = SECT_BYTES + CODE_BYTES - 1,
    localparam int PW        = $clog2(SPAN),
    localparam int DADDR_W   = $clog2(SECT_BYTES),
    localparam int SADDR_W   = $clog2(CODE_BYTES)
) (
    input  logic [LOC_W-1:0]   loc,
    output tgt_t               kind,
    output logic [DADDR_W-1:0] daddr,
    output logic [SADDR_W-1:0] saddr,
    output logic [7:0]         mask
);
    logic [LOC_W-1:0] back;
    logic [PW-1:0]    pos;
    logic [PW-1:0]    spos;

    assign back = {3'b000, loc[LOC_W-1:3]};
    assign mask = 8'h01 << loc[2:0];

    always_comb begin
        kind  = TGT_BAD;
        pos   = '0;
        spos  = '0;
        daddr = '0;
        saddr = '0;
        if (back < LOC_W'(SPAN)) begin
            pos = PW'(SPAN - 1) - PW'(back);
            if (pos < PW'(SECT_BYTES)) begin
                kind  = TGT_DATA;
                daddr = pos[DADDR_W-1:0];
            end else begin
                kind  = TGT_SPARE;
                spos  = pos - PW'(SECT_BYTES);
                saddr = spos[SADDR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/bch8_loc_apply.sv
module bch8_loc_apply
    import bchfix_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int CODE_BYTES = 14,
    parameter int MAX_ERR    = 8,
    parameter int LOC_W      = 13,
    localparam int CNT_W     = $clog2(MAX_ERR + 1),
    localparam int IDX_W     = $clog2(MAX_ERR),
    localparam int DADDR_W   = $clog2(SECT_BYTES),
    localparam int SADDR_W   = $clog2(CODE_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       uncorr,
    input  logic [CNT_W-1:0]           err_cnt,
    input  logic [MAX_ERR*LOC_W-1:0]   locs,
    input  logic [CODE_BYTES*8-1:0]    calc_code,
    input  logic [CODE_BYTES*8-1:0]    stored_code,
    output logic [CODE_BYTES*8-1:0]    loc_code,
    output logic                       dat_rd_en,
    output logic                       dat_wr_en,
    output logic [DADDR_W-1:0]         dat_addr,
    output logic [7:0]                 dat_wdata,
    input  logic [7:0]                 dat_rdata,
    output logic                       spr_wr_en,
    output logic [SADDR_W-1:0]         spr_addr,
    output logic [7:0]                 spr_wdata,
    output logic                       busy,
    output logic                       done,
    output logic                       fail,
    output logic [CNT_W-1:0]           fixed_cnt
);
    typedef struct packed {
        fsm_t                     st;
        logic [IDX_W-1:0]         idx;
        logic [CNT_W-1:0]         n;
        logic [MAX_ERR*LOC_W-1:0] locs;
        logic                     bad;
        logic                     done;
        logic                     fail;
        logic [CNT_W-1:0]         cnt;
    } state_t;

    state_t q, d;

    logic               calc_zero, erased;
    logic [LOC_W-1:0]   cur_loc;
    tgt_t               kind;
    logic [DADDR_W-1:0] daddr;
    logic [SADDR_W-1:0] saddr;
    logic [7:0]         mask;
    logic [CNT_W-1:0]   n_clamp;
    logic               last;
    logic               bad_now;

    bchfix_screen #(.CODE_BYTES(CODE_BYTES)) u_screen (
        .calc_code   (calc_code),
        .stored_code (stored_code),
        .calc_zero   (calc_zero),
        .erased      (erased),
        .loc_code    (loc_code)
    );

    assign cur_loc = q.locs[q.idx*LOC_W +: LOC_W];

    bchfix_locmap #(
        .SECT_BYTES (SECT_BYTES),
        .CODE_BYTES (CODE_BYTES),
        .LOC_W      (LOC_W)
    ) u_map (
        .loc   (cur_loc),
        .kind  (kind),
        .daddr (daddr),
        .saddr (saddr),
        .mask  (mask)
    );

    assign n_clamp = (err_cnt > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : err_cnt;
    assign last    = (CNT_W'(q.idx) + CNT_W'(1)) == q.n;
    assign bad_now = q.bad | (kind == TGT_BAD);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.cnt  = '0;
                    d.fail = 1'b0;
                    if (uncorr) begin
                        d.done = 1'b1;
                        d.fail = 1'b1;
                    end else if (calc_zero || erased || n_clamp == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st   = ST_RD;
                        d.idx  = '0;
                        d.n    = n_clamp;
                        d.locs = locs;
                        d.bad  = 1'b0;
                    end
                end
            end
            ST_RD: begin
                d.st = ST_WR;
            end
            ST_WR: begin
                d.bad = bad_now;
                if (last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.fail = bad_now;
                    d.cnt  = bad_now ? '0 : q.n;
                end else begin
                    d.st  = ST_RD;
                    d.idx = q.idx + IDX_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.idx  <= '0;
            q.n    <= '0;
            q.locs <= '0;
            q.bad  <= 1'b0;
            q.done <= 1'b0;
            q.fail <= 1'b0;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign dat_rd_en = (q.st == ST_RD) && (kind == TGT_DATA);
    assign dat_wr_en = (q.st == ST_WR) && (kind == TGT_DATA);
    assign dat_addr  = daddr;
    assign dat_wdata = dat_rdata ^ mask;
    assign spr_wr_en = (q.st == ST_WR) && (kind == TGT_SPARE);
    assign spr_addr  = saddr;
    assign spr_wdata = mask;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign fail      = q.fail;
    assign fixed_cnt = q.cnt;

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr_en |-> $past(dat_rd_en)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FAIL_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (fixed_cnt == '0)); // R7
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_cnt <= CNT_W'(MAX_ERR)); // R8
    AST_SCREEN_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (uncorr || calc_zero || erased)) |=> (done && !busy)); // R3
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy); // R11
endmodule

// File: tb/sim_bch8_loc_apply.sv
module sim_bch8_loc_apply;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         uncorr = 1'b0;
    logic [3:0]   err_cnt = '0;
    logic [103:0] locs = '0;
    logic [111:0] calc_code = '0;
    logic [111:0] stored_code = '0;
    logic [111:0] loc_code;
    logic         dat_rd_en, dat_wr_en, spr_wr_en;
    logic [8:0]   dat_addr;
    logic [7:0]   dat_wdata, spr_wdata;
    logic [7:0]   dat_rdata = '0;
    logic [3:0]   spr_addr;
    logic         busy, done, fail;
    logic [3:0]   fixed_cnt;

    int tests = 0;
    int fails = 0;

    logic [7:0]  dmem [512];
    logic [7:0]  smem [14];
    logic [7:0]  mdat [512];
    logic [7:0]  mspr [14];
    logic [12:0] tl [8];

    always #4 clk = ~clk;

    bch8_loc_apply u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .uncorr(uncorr),
        .err_cnt(err_cnt), .locs(locs), .calc_code(calc_code),
        .stored_code(stored_code), .loc_code(loc_code),
        .dat_rd_en(dat_rd_en), .dat_wr_en(dat_wr_en), .dat_addr(dat_addr),
        .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .spr_wr_en(spr_wr_en),
        .spr_addr(spr_addr), .spr_wdata(spr_wdata), .busy(busy),
        .done(done), .fail(fail), .fixed_cnt(fixed_cnt)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) dmem[i] <= 8'(i * 7 + 3);
            for (int i = 0; i < 14; i++) smem[i] <= 8'(i * 5 + 1);
        end else begin
            if (dat_rd_en) dat_rdata <= dmem[dat_addr];
            if (dat_wr_en) dmem[dat_addr] <= dat_wdata;
            if (spr_wr_en) smem[spr_addr] <= spr_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int bad_d = 0;
        int bad_s = 0;
        for (int i = 0; i < 512; i++) if (dmem[i] !== mdat[i]) bad_d++;
        for (int i = 0; i < 14; i++) if (smem[i] !== mspr[i]) bad_s++;
        check(bad_d == 0, {req, " data buffer mismatches"}, bad_d, 0);
        check(bad_s == 0, {req, " spare buffer mismatches"}, bad_s, 0);
    endtask

    // behavioural model: expected edge count, count, fail; updates mdat/mspr
    task automatic run(input string req, input bit poke);
        int  exp_k, exp_cnt, n, k;
        bit  exp_fail, bad;
        exp_fail = 0; exp_cnt = 0; exp_k = 0; bad = 0;
        if (uncorr) begin
            exp_fail = 1;
        end else if (calc_code == '0 || stored_code == '1) begin
            exp_k = 0;
        end else begin
            n = (err_cnt > 8) ? 8 : int'(err_cnt);
            for (int i = 0; i < n; i++) begin
                int back, pos;
                back = int'(tl[i]) / 8;
                if (back > 524) bad = 1;
                else begin
                    pos = 524 - back;
                    if (pos < 512) mdat[pos] = mdat[pos] ^ (8'h01 << (tl[i] % 8));
                    else mspr[pos - 512] = 8'h01 << (tl[i] % 8);
                end
            end
            exp_k = 2 * n;
            exp_fail = bad;
            exp_cnt = bad ? 0 : n;
        end
        for (int i = 0; i < 8; i++) locs[i*13 +: 13] = tl[i];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 64) begin
            if (poke && k == 1) begin start = 1'b1; uncorr = 1'b1; end
            else start = 1'b0;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check(k == exp_k, {req, " done timing (edges after start)"}, k, exp_k);
        check(fail == exp_fail, {req, " fail flag"}, int'(fail), int'(exp_fail));
        check(int'(fixed_cnt) == exp_cnt, {req, " fixed count"}, int'(fixed_cnt), exp_cnt);
        @(negedge clk);
        check(done == 1'b0, {req, " done is single pulse (R9)"}, int'(done), 0);
        check_mem(req);
        uncorr = 1'b0;
    endtask

    task automatic set_codes();
        for (int i = 0; i < 14; i++) begin
            calc_code[i*8 +: 8]   = 8'(i + 1);
            stored_code[i*8 +: 8] = 8'(8'hF0 ^ i);
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mdat[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 14; i++) mspr[i] = 8'(i * 5 + 1);
        for (int i = 0; i < 8; i++) tl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(done == 0 && busy == 0 && fail == 0 && fixed_cnt == 0, "reset outputs",
              int'({done, busy, fail, fixed_cnt}), 0);
        check(dat_wr_en == 0 && spr_wr_en == 0, "reset write strobes",
              int'({dat_wr_en, spr_wr_en}), 0);

        // R1 reversal
        set_codes();
        #1;
        for (int i = 0; i < 13; i++)
            check(loc_code[i*8 +: 8] == 8'(13 - i), "R1 reversed byte",
                  int'(loc_code[i*8 +: 8]), 13 - i);
        check(loc_code[104 +: 8] == 8'h00, "R1 reserved byte", int'(loc_code[104 +: 8]), 0);

        // R2 uncorrectable
        tl[0] = 13'd40; err_cnt = 4'd1; uncorr = 1'b1;
        run("R2", 0);

        // R3 computed code all zero
        calc_code = '0; err_cnt = 4'd3; tl[0] = 13'd9; tl[1] = 13'd200; tl[2] = 13'd3000;
        run("R3", 0);

        // R4 erased sector
        set_codes(); stored_code = '1; err_cnt = 4'd2;
        run("R4", 0);

        // R5 single data location at first data byte
        set_codes(); err_cnt = 4'd1; tl[0] = 13'd4199;
        run("R5 single", 0);
        // R5 mixed data and spare
        err_cnt = 4'd3; tl[0] = 13'd104; tl[1] = 13'd2051; tl[2] = 13'd7;
        run("R5 mixed", 0);

        // R6 spare overwrite at both ends
        err_cnt = 4'd2; tl[0] = 13'd100; tl[1] = 13'd0;
        run("R6", 0);

        // R7 invalid location mixed with valid ones
        err_cnt = 4'd3; tl[0] = 13'd4200; tl[1] = 13'd50; tl[2] = 13'd8000;
        run("R7", 0);

        // R8 count clamped to eight
        err_cnt = 4'd12;
        for (int i = 0; i < 8; i++) tl[i] = 13'(i * 517 + 11);
        run("R8", 0);

        // duplicate location restores the byte (R9 ordering)
        err_cnt = 4'd2; tl[0] = 13'd300; tl[1] = 13'd300;
        run("R9 duplicate", 0);

        // R10 zero count
        err_cnt = 4'd0;
        run("R10", 0);

        // R11 start during busy ignored
        err_cnt = 4'd2; tl[0] = 13'd1234; tl[1] = 13'd77;
        run("R11", 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule